// File: doc/BRIEF.md
# UART Receive/Transmit FIFO and Interrupt Core

This block sits between a host register port and the serial side of a 16550-style UART. It buffers bytes delivered by a receiver (and break events, which arrive as a zero byte) in a receive queue. It buffers bytes written by the host in a transmit queue that a shifter drains. It keeps the line-status flags, runs a character-timeout timer, and resolves pending sources into a prioritised interrupt identification code and a single interrupt line.

The host reaches it through a 3-bit address with read and write strobes. Address 0 reads the oldest received byte or writes a transmit byte. Address 1 holds the interrupt enables. Address 2 reads the identification code and writes the queue control byte. Address 5 reads line status. With the queues disabled, each direction holds a single byte. With them enabled, each holds `DEPTH` bytes.

Top module: `uart_fifo_intc`

## Requirements
- R1: After reset, line status reads 0x60 (bit 6 idle transmitter, bit 5 transmit queue empty), the identification register reads 0x01 (nothing pending), irq is low and tx_valid is low.
- R2: Queue control bits 7:6 pick the receive trigger level (00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14). With queues enabled, receive-data interrupt code 0x04 needs the byte count at or above that level. With queues disabled, one held byte is enough.
- R3: A byte that arrives while the receive queue is full (16 entries, or 1 with queues disabled) is dropped, the stored bytes are returned unchanged and in order, and overrun flag bit 1 of line status is set.
- R4: A host data write to a full transmit queue discards the oldest byte, so the shifter next sees the second-oldest byte.
- R5: A host data write clears line-status bit 5 (queue empty) and bit 6 (transmitter idle). Bit 5 returns when the queue empties. Bit 6 returns one cycle after the queue is empty and tx_busy is low.
- R6: rx_break enqueues 0x00 and sets line-status bit 4 (break) and bit 0 (data ready).
- R7: With queues enabled, a non-empty receive queue left unread for 4 character times (4·CLK_HZ·10/9600 clocks after the last arrival or read) raises timeout code 0x0C. A data read clears it and restarts the timer.
- R8: A data read that empties the receive queue clears data ready and break. A data read of an empty queue returns 0x00 and changes nothing.
- R9: Identification priority is timeout, then receive data, then transmit empty (0x02). Enable bit 0 gates the first two, enable bit 1 gates the last. Bits 7:6 read 11 when queues are enabled. irq is high exactly when some code other than 0x01 is pending.
- R10: Queue control bit 0 enables the queues, bit 1 empties the receive queue and cancels a pending timeout, and bit 2 empties the transmit queue. Changing bit 0 empties both queues.
- R11: A line-status read clears the overrun flag unless a new overrun happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Host register address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (data reads pop) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from addr |
| rx_valid | input | 1 | Receiver delivers rx_data this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Receiver detected a break |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Shifter takes tx_data this cycle |
| tx_busy | input | 1 | Shifter still sending a character |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the two full-queue cases. A receive path that evicts old bytes instead of dropping the new one returns a shifted sequence after the overrun. A transmit path that refuses the write presents the wrong head byte. Each trigger level is walked one byte at a time, because an off-by-one compare raises irq one byte early or late. The timeout is probed on the cycle before and the cycle of its expiry, then after a re-arming read, because a timer that is not restarted or is gated wrongly fires at the wrong cycle or hides behind the transmit-empty source. Break, empty reads and queue resets are checked through line status, where a break flag left set or a stale timeout would show.

// File: rtl/ufi_pkg.sv
package ufi_pkg;

   localparam logic [2:0] ADR_DATA  = 3'd0;
   localparam logic [2:0] ADR_IEN   = 3'd1;
   localparam logic [2:0] ADR_IDCTL = 3'd2;
   localparam logic [2:0] ADR_LSTAT = 3'd5;

   typedef enum logic [3:0] {
      IID_NONE = 4'h1,
      IID_TXE  = 4'h2,
      IID_RXD  = 4'h4,
      IID_TOUT = 4'hC
   } iid_e;

   function automatic logic [4:0] trig_level(input logic [1:0] sel);
      case (sel)
         2'b00:   return 5'd1;
         2'b01:   return 5'd4;
         2'b10:   return 5'd8;
         default: return 5'd14;
      endcase
   endfunction

endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
   parameter int DEPTH       = 16,
   parameter int WIDTH       = 8,
   parameter bit DROP_OLDEST = 1'b0,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             single,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             ovf
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("ufi_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    rp, wp;
   logic [CW-1:0]    cnt;
   logic             full, do_pop, room, accept, advance_rd;

   assign full   = single ? (cnt != '0) : (cnt == CW'(DEPTH));
   assign do_pop = pop & (cnt != '0);
   assign room   = ~full | do_pop;

   if (DROP_OLDEST) begin : g_evict
      assign accept     = push & ~flush;
      assign advance_rd = do_pop | (push & ~room);
      assign ovf        = 1'b0;
   end else begin : g_reject
      assign accept     = push & room & ~flush;
      assign advance_rd = do_pop;
      assign ovf        = push & ~room & ~flush;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (accept)     wp <= wp + 1'b1;
         if (advance_rd) rp <= rp + 1'b1;
         cnt <= cnt + CW'(accept) - CW'(advance_rd);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign count = cnt;

   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   if (DROP_OLDEST) begin : g_evict_chk
      p_evict_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (push && full && !do_pop && !flush) |=> (cnt == $past(cnt)));
   end else begin : g_reject_chk
      p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (push && full && !do_pop && !flush) |=> (cnt == $past(cnt) && rp == $past(rp)));
   end

endmodule

// File: rtl/ufi_char_timer.sv
module ufi_char_timer #(
   parameter int LIMIT = 400,
   localparam int TW = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic clear,
   input  logic restart,
   input  logic ack,
   input  logic has_data,
   output logic pending
);

   if (LIMIT < 2) begin : g_limit_chk
      $error("ufi_char_timer: LIMIT too small");
   end

   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt    <= '0;
         pending <= 1'b0;
      end else if (clear || !enable) begin
         tcnt    <= '0;
         pending <= 1'b0;
      end else if (restart || ack) begin
         tcnt <= '0;
         if (ack) pending <= 1'b0;
      end else if (!has_data) begin
         tcnt    <= '0;
         pending <= 1'b0;
      end else if (tcnt == TW'(LIMIT - 1)) begin
         pending <= 1'b1;
      end else begin
         tcnt <= tcnt + 1'b1;
      end
   end

   p_pend_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> has_data);
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !pending);
   p_rise_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> ($past(tcnt) == TW'(LIMIT - 1)));

endmodule

// File: rtl/ufi_irq_prio.sv
module ufi_irq_prio
   import ufi_pkg::*;
#(
   parameter int CW = 5
) (
   input  logic          fifo_on,
   input  logic [1:0]    ien,
   input  logic [1:0]    trig,
   input  logic [CW-1:0] rx_cnt,
   input  logic          tout,
   input  logic          thre,
   output iid_e          iid,
   output logic          irq
);

   logic src_to, src_rx, src_tx;

   assign src_to = ien[0] & fifo_on & tout;
   assign src_rx = ien[0] & (rx_cnt != '0) &
                   (~fifo_on | (rx_cnt >= CW'(trig_level(trig))));
   assign src_tx = ien[1] & thre;

   always_comb begin
      if (src_to)      iid = IID_TOUT;
      else if (src_rx) iid = IID_RXD;
      else if (src_tx) iid = IID_TXE;
      else             iid = IID_NONE;
   end

   assign irq = src_to | src_rx | src_tx;

endmodule

// File: rtl/uart_fifo_intc.sv
module uart_fifo_intc
   import ufi_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int CLK_HZ    = 50_000_000,
   parameter int BAUD      = 9600,
   parameter int CHAR_BITS = 10,
   localparam int CHAR_CLKS = CLK_HZ / BAUD * CHAR_BITS,
   localparam int TO_LIMIT  = 4 * CHAR_CLKS,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_break,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       tx_take,
   input  logic       tx_busy,
   output logic       irq
);

   if (DEPTH < 16) begin : g_depth_chk
      $error("uart_fifo_intc: DEPTH must cover the top trigger level");
   end
   if (CLK_HZ < BAUD * CHAR_BITS) begin : g_clk_chk
      $error("uart_fifo_intc: clock too slow for the character rate");
   end

   logic          fifo_on, oe, bi, temt;
   logic [1:0]    trig, ien;
   logic          thr_wr, ien_wr, ctl_wr, data_rd, lstat_rd;
   logic          rx_flush, tx_flush, rx_push, rx_pop, rx_ovf, tx_pop;
   logic [7:0]    rx_din, rx_head, lstat;
   logic [CW-1:0] rx_cnt, tx_cnt;
   logic          dr, thre, tout;
   iid_e          iid;

   assign thr_wr   = wr_en & (addr == ADR_DATA);
   assign ien_wr   = wr_en & (addr == ADR_IEN);
   assign ctl_wr   = wr_en & (addr == ADR_IDCTL);
   assign data_rd  = rd_en & (addr == ADR_DATA);
   assign lstat_rd = rd_en & (addr == ADR_LSTAT);

   assign rx_flush = ctl_wr & (wdata[1] | (wdata[0] ^ fifo_on));
   assign tx_flush = ctl_wr & (wdata[2] | (wdata[0] ^ fifo_on));
   assign rx_push  = rx_valid | rx_break;
   assign rx_din   = rx_break ? 8'h00 : rx_data;
   assign dr       = (rx_cnt != '0);
   assign rx_pop   = data_rd & dr;
   assign thre     = (tx_cnt == '0);
   assign tx_valid = ~thre;
   assign tx_pop   = tx_take & tx_valid;

   ufi_fifo #(.DEPTH(DEPTH), .WIDTH(8), .DROP_OLDEST(1'b0)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(~fifo_on),
      .push(rx_push), .din(rx_din), .pop(rx_pop),
      .dout(rx_head), .count(rx_cnt), .ovf(rx_ovf)
   );

   logic tx_ovf_unused;
   ufi_fifo #(.DEPTH(DEPTH), .WIDTH(8), .DROP_OLDEST(1'b1)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(~fifo_on),
      .push(thr_wr), .din(wdata), .pop(tx_pop),
      .dout(tx_data), .count(tx_cnt), .ovf(tx_ovf_unused)
   );

   ufi_char_timer #(.LIMIT(TO_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(fifo_on), .clear(rx_flush),
      .restart(rx_push), .ack(rx_pop), .has_data(dr), .pending(tout)
   );

   ufi_irq_prio #(.CW(CW)) u_prio (
      .fifo_on(fifo_on), .ien(ien), .trig(trig), .rx_cnt(rx_cnt),
      .tout(tout), .thre(thre), .iid(iid), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_on <= 1'b0;
         trig    <= 2'b00;
         ien     <= 2'b00;
         oe      <= 1'b0;
         bi      <= 1'b0;
         temt    <= 1'b1;
      end else begin
         if (ctl_wr) begin
            fifo_on <= wdata[0];
            trig    <= wdata[7:6];
         end
         if (ien_wr) ien <= wdata[1:0];

         if (rx_ovf)        oe <= 1'b1;
         else if (lstat_rd) oe <= 1'b0;

         if (rx_flush)                               bi <= 1'b0;
         else if (rx_break)                          bi <= 1'b1;
         else if (rx_pop && rx_cnt == CW'(1))        bi <= 1'b0;

         if (thr_wr) temt <= 1'b0;
         else        temt <= thre & ~tx_busy;
      end
   end

   assign lstat = {1'b0, temt, thre, bi, 2'b00, oe, dr};

   always_comb begin
      case (addr)
         ADR_DATA:  rdata = dr ? rx_head : 8'h00;
         ADR_IEN:   rdata = {6'b0, ien};
         ADR_IDCTL: rdata = {fifo_on, fifo_on, 2'b00, iid};
         ADR_LSTAT: rdata = lstat;
         default:   rdata = 8'h00;
      endcase
   end

   p_thr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> (!lstat[5] && !lstat[6]));
   p_break_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_break && !rx_flush) |=> (lstat[4] && lstat[0]));
   p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> lstat[1]);
   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !dr && !rx_push) |=> (rx_cnt == '0 && $stable(bi)));
   p_tout_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tout && fifo_on && ien[0]) |-> (iid == IID_TOUT && irq));
   p_rx_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (rx_cnt == '0 && !tout));

endmodule

// File: tb/sim_uart_fifo_intc.sv
module sim_uart_fifo_intc;

   localparam int LIMIT = 400;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 0, rd_en = 0, rx_valid = 0, rx_break = 0, tx_take = 0, tx_busy = 0;
   logic [7:0] wdata = '0, rx_data = '0;
   logic [7:0] rdata, tx_data;
   logic       tx_valid, irq;

   int checks = 0, errors = 0, cyc = 0;

   always #2.5 clk = ~clk;

   uart_fifo_intc #(.DEPTH(16), .CLK_HZ(96000), .BAUD(9600), .CHAR_BITS(10)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_take(tx_take), .tx_busy(tx_busy), .irq(irq)
   );

   // behavioural reference
   bit         m_fe, m_oe, m_bi, m_temt = 1, m_pend;
   bit [1:0]   m_trig, m_ier;
   int         m_tcnt;
   byte unsigned rxq[$], txq[$];

   function automatic int lvl(bit [1:0] t);
      return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
   endfunction

   function automatic bit [3:0] m_code();
      bit dr = rxq.size() > 0;
      if (m_ier[0] && m_fe && m_pend) return 4'hC;
      if (m_ier[0] && dr && (!m_fe || rxq.size() >= lvl(m_trig))) return 4'h4;
      if (m_ier[1] && txq.size() == 0) return 4'h2;
      return 4'h1;
   endfunction

   function automatic bit [7:0] m_read(bit [2:0] a);
      case (a)
         3'd0: return rxq.size() > 0 ? rxq[0] : 8'h00;
         3'd1: return {6'b0, m_ier};
         3'd2: return {m_fe, m_fe, 2'b00, m_code()};
         3'd5: return {1'b0, m_temt, txq.size() == 0, m_bi, 2'b00, m_oe, rxq.size() > 0};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_step();
      bit thr_w = wr_en && addr == 0, ctl_w = wr_en && addr == 2, ien_w = wr_en && addr == 1;
      bit drd = rd_en && addr == 0, lrd = rd_en && addr == 5;
      int old_rx = rxq.size(), old_tx = txq.size();
      bit rxp = drd && old_rx > 0, push = rx_valid || rx_break;
      bit rfl = ctl_w && (wdata[1] || (wdata[0] != m_fe));
      bit tfl = ctl_w && (wdata[2] || (wdata[0] != m_fe));
      int cap = m_fe ? 16 : 1;
      bit ovf = 0;
      // timer
      if (rfl || !m_fe) begin m_tcnt = 0; m_pend = 0; end
      else if (push || rxp) begin m_tcnt = 0; if (rxp) m_pend = 0; end
      else if (old_rx == 0) begin m_tcnt = 0; m_pend = 0; end
      else if (m_tcnt == LIMIT - 1) m_pend = 1;
      else m_tcnt++;
      // receive side
      if (rfl) begin rxq.delete(); m_bi = 0; end
      else begin
         if (rxp) void'(rxq.pop_front());
         if (push) begin
            if (rxq.size() < cap) rxq.push_back(rx_break ? 8'h00 : rx_data);
            else ovf = 1;
         end
         if (rx_break) m_bi = 1;
         else if (rxp && old_rx == 1) m_bi = 0;
      end
      if (ovf) m_oe = 1; else if (lrd) m_oe = 0;
      // transmit side
      m_temt = thr_w ? 0 : (old_tx == 0 && !tx_busy);
      if (tfl) txq.delete();
      else begin
         if (tx_take && old_tx > 0) void'(txq.pop_front());
         if (thr_w) begin
            if (txq.size() >= cap) void'(txq.pop_front());
            txq.push_back(wdata);
         end
      end
      if (ctl_w) begin m_fe = wdata[0]; m_trig = wdata[7:6]; end
      if (ien_w) m_ier = wdata[1:0];
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R9 irq", irq, m_code() != 4'h1);
      chk("R5 tx_valid", tx_valid, txq.size() > 0);
      if (tx_valid && txq.size() > 0) chk("R4 tx_data", tx_data, txq[0]);
   endtask

   task automatic idle();
      wr_en = 0; rd_en = 0; rx_valid = 0; rx_break = 0;
   endtask

   task automatic rdx(bit [2:0] a, bit [7:0] exp, string tag);
      addr = a; rd_en = 1; #1;
      chk(tag, rdata, exp);
      chk({tag, " model"}, rdata, m_read(a));
      tick(); idle();
   endtask

   task automatic wr(bit [2:0] a, bit [7:0] d);
      addr = a; wdata = d; wr_en = 1; tick(); idle();
   endtask

   task automatic rxb(bit [7:0] b);
      rx_data = b; rx_valid = 1; tick(); idle();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 tx_valid", tx_valid, 0);
      rdx(5, 8'h60, "R1 lstat");
      rdx(2, 8'h01, "R1 iid");
      // non-queued mode: one-byte holding, overrun, flag clear
      wr(1, 8'h01);
      rxb(8'h41);
      rdx(2, 8'h04, "R2 single-byte data interrupt");
      rxb(8'h42);
      rdx(5, 8'h63, "R3 overrun flag");
      rdx(5, 8'h61, "R11 overrun cleared by status read");
      rdx(0, 8'h41, "R3 first byte kept");
      rdx(5, 8'h60, "R8 data ready cleared");
      rdx(0, 8'h00, "R8 empty read returns zero");
      rdx(5, 8'h60, "R8 empty read no change");
      // trigger levels
      for (int t = 0; t < 4; t++) begin
         wr(2, {t[1:0], 6'b000111});
         for (int k = 1; k <= lvl(t[1:0]); k++) begin
            rxb(8'(k));
            chk("R2 trigger level irq", irq, k >= lvl(t[1:0]));
         end
         rdx(2, 8'hC4, "R2 level reached");
      end
      // receive overrun with queues on
      rxb(8'd15); rxb(8'd16); rxb(8'hEE);
      rdx(5, 8'h63, "R3 queue overrun flag");
      for (int k = 1; k <= 16; k++) rdx(0, 8'(k), "R3 contents unchanged");
      rdx(5, 8'h60, "R8 emptied");
      // character timeout
      rxb(8'h55); rxb(8'h66);
      repeat (LIMIT - 1) tick();
      chk("R7 not yet expired", irq, 0);
      tick();
      chk("R7 expired", irq, 1);
      rdx(2, 8'hCC, "R7 timeout code");
      rdx(0, 8'h55, "R7 read byte");
      rdx(2, 8'hC1, "R7 cleared by read");
      repeat (LIMIT) tick();
      rdx(2, 8'hCC, "R7 re-armed");
      wr(1, 8'h03);
      rdx(2, 8'hCC, "R9 timeout over transmit empty");
      wr(2, 8'hC3);
      rdx(2, 8'hC2, "R10 receive reset cancels timeout");
      rdx(5, 8'h60, "R10 receive queue empty");
      // transmit overwrite and status
      for (int k = 0; k < 18; k++) wr(0, 8'(8'h10 + k));
      chk("R4 oldest discarded", tx_data, 8'h12);
      rdx(5, 8'h00, "R5 write clears empty and idle");
      rdx(2, 8'hC1, "R5 no transmit interrupt");
      tx_busy = 1; tx_take = 1;
      repeat (16) tick();
      tx_take = 0;
      rdx(5, 8'h20, "R5 empty but shifter busy");
      tx_busy = 0; tick();
      rdx(5, 8'h60, "R5 idle again");
      wr(0, 8'hA0); wr(0, 8'hA1); wr(0, 8'hA2);
      wr(2, 8'hC5);
      chk("R10 transmit reset", tx_valid, 0);
      tick();
      rdx(5, 8'h60, "R10 status after transmit reset");
      // break
      wr(1, 8'h00);
      rx_break = 1; tick(); idle();
      rdx(5, 8'h71, "R6 break flags");
      rdx(0, 8'h00, "R6 break byte");
      rdx(5, 8'h60, "R8 break cleared by emptying read");
      // single-byte transmit overwrite
      wr(2, 8'h00);
      wr(0, 8'hB1); wr(0, 8'hB2);
      chk("R4 single-byte overwrite", tx_data, 8'hB2);
      tx_take = 1; tick(); tx_take = 0; tick();
      chk("R5 drained", tx_valid, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule